// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a write-back cache (or a processor) and main memory. It turns each store into a posted write. A write is taken into a small first-in first-out store in the cycle it is presented, so the requester goes on working. The buffer then drains its entries to memory one at a time over a request/acknowledge port.

When every slot is occupied, the block raises a stall. A write presented during the stall is held off until a memory acknowledge frees a slot.

Buffered data cannot be read back through this block. To keep reads correct, a read address probe is compared against every pending entry. A hazard flag tells the requester to wait until the matching write has reached memory.

Top module: `wbuf_top`

## Requirements
- R1: While fewer than DEPTH entries are pending, `cpu_stall` is low and a write presented with `cpu_wr_valid` is taken at that rising clock edge, with no dependence on memory.
- R2: `mem_req` is high whenever at least one entry is pending. `mem_addr`, `mem_data` and `mem_be` then show the oldest pending entry and stay unchanged until the cycle in which `mem_ack` is high.
- R3: Entries reach memory in the order they were accepted, each exactly once. An entry leaves the buffer only at a rising edge where `mem_req` and `mem_ack` are both high, and `mem_ack` while `mem_req` is low has no effect.
- R4: While DEPTH entries are pending and `mem_ack` is low, `cpu_stall` is high and a presented write is not taken. The occupancy never exceeds DEPTH.
- R5: While DEPTH entries are pending and `mem_ack` is high in the same cycle, `cpu_stall` is low. The presented write is taken at the same edge at which the oldest entry retires.
- R6: `buf_empty` is a registered output that is high exactly when no entry is pending. This includes the entry being offered to memory, so `buf_empty` is the inverse of `mem_req`.
- R7: `rd_hazard` is high in a cycle exactly when some pending entry, including the one awaiting acknowledge, holds an address equal to `rd_addr`. Writes being presented in that same cycle are not counted.
- R8: The byte-enable bits given with a write are delivered on `mem_be` unchanged, together with that write's address and data.
- R9: After reset, `mem_req`, `cpu_stall` and `rd_hazard` are low and `buf_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_valid | input | 1 | A write is presented |
| cpu_wr_addr | input | ADDR_W | Write address |
| cpu_wr_data | input | DATA_W | Write data |
| cpu_wr_be | input | DATA_W/8 | Byte enables of the write |
| cpu_stall | output | 1 | Buffer cannot take a write this cycle |
| rd_addr | input | ADDR_W | Address of a pending read, probed for conflicts |
| rd_hazard | output | 1 | A pending write matches `rd_addr` |
| mem_req | output | 1 | A write is offered to memory |
| mem_addr | output | ADDR_W | Address of the offered write |
| mem_data | output | DATA_W | Data of the offered write |
| mem_be | output | DATA_W/8 | Byte enables of the offered write |
| mem_ack | input | 1 | Memory has taken the offered write |
| buf_empty | output | 1 | No write is pending |

## Verification
Back-to-back writes against a memory that never acknowledges fill the buffer. Holding the next write then separates correct stalling (R4) from overflow. Adding an acknowledge in that same full cycle separates a correct same-edge swap (R5) from needless stalling.

Stray acknowledges while idle, and a write coinciding with such an acknowledge, show whether a retire can be taken from an empty buffer. Random traffic then runs with acknowledge rates swept from sparse to constant. Most addresses are drawn from a sixteen-word window, so duplicate addresses among pending entries often make the hazard probe hit, including on the entry currently offered to memory. Head contents are compared at every acknowledge, which exposes reordering, loss or duplication.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Advance a circular slot index, wrapping at the slot count.
  function automatic int unsigned ptr_after(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             mem_ack,
  output logic             push,
  output logic             pop,
  output logic             stall,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] occ,
  output logic [DEPTH-1:0] valid_vec,
  output logic             empty
);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] occ_q, occ_n;
  logic [DEPTH-1:0] vld_q;
  logic             empty_q;
  logic             full;

  assign full  = (occ_q == CNT_W'(DEPTH));
  assign pop   = (occ_q != '0) && mem_ack;
  // A retire in the same cycle frees the slot the new write needs.
  assign stall = full && !mem_ack;
  assign push  = wr_req && !stall;

  always_comb begin
    occ_n = occ_q;
    case ({push, pop})
      2'b10:   occ_n = occ_q + CNT_W'(1);
      2'b01:   occ_n = occ_q - CNT_W'(1);
      default: occ_n = occ_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
      vld_q    <= '0;
      empty_q  <= 1'b1;
    end else begin
      occ_q   <= occ_n;
      empty_q <= (occ_n == '0);
      if (pop) begin
        rd_ptr_q        <= PTR_W'(wbuf_pkg::ptr_after(32'(rd_ptr_q), DEPTH));
        vld_q[rd_ptr_q] <= 1'b0;
      end
      if (push) begin
        wr_ptr_q        <= PTR_W'(wbuf_pkg::ptr_after(32'(wr_ptr_q), DEPTH));
        vld_q[wr_ptr_q] <= 1'b1;
      end
    end
  end

  assign wr_ptr    = wr_ptr_q;
  assign rd_ptr    = rd_ptr_q;
  assign occ       = occ_q;
  assign valid_vec = vld_q;
  assign empty     = empty_q;

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [PTR_W-1:0]        wptr,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [BE_W-1:0]         wbe,
  input  logic [PTR_W-1:0]        rptr,
  output logic [ADDR_W-1:0]       head_addr,
  output logic [DATA_W-1:0]       head_data,
  output logic [BE_W-1:0]         head_be,
  output logic [DEPTH*ADDR_W-1:0] addr_all
);

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [BE_W-1:0]   be_mem   [DEPTH];

  // Storage has no reset; slot validity lives in the controller.
  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[wptr] <= waddr;
      data_mem[wptr] <= wdata;
      be_mem[wptr]   <= wbe;
    end
  end

  assign head_addr = addr_mem[rptr];
  assign head_data = data_mem[rptr];
  assign head_be   = be_mem[rptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_addr_tap
    assign addr_all[i*ADDR_W +: ADDR_W] = addr_mem[i];
  end

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic [DEPTH*ADDR_W-1:0] addr_all,
  input  logic [DEPTH-1:0]        valid_vec,
  input  logic [ADDR_W-1:0]       probe,
  output logic                    hit
);

  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = valid_vec[i] && (addr_all[i*ADDR_W +: ADDR_W] == probe);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_valid,
  input  logic [ADDR_W-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic [BE_W-1:0]   cpu_wr_be,
  output logic              cpu_stall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hazard,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack,
  output logic              buf_empty
);

  logic                    push, pop;
  logic [PTR_W-1:0]        wr_ptr, rd_ptr;
  logic [CNT_W-1:0]        occ;
  logic [DEPTH-1:0]        valid_vec;
  logic [DEPTH*ADDR_W-1:0] addr_all;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (cpu_wr_valid),
    .mem_ack   (mem_ack),
    .push      (push),
    .pop       (pop),
    .stall     (cpu_stall),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .occ       (occ),
    .valid_vec (valid_vec),
    .empty     (buf_empty)
  );

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .we        (push),
    .wptr      (wr_ptr),
    .waddr     (cpu_wr_addr),
    .wdata     (cpu_wr_data),
    .wbe       (cpu_wr_be),
    .rptr      (rd_ptr),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .head_be   (mem_be),
    .addr_all  (addr_all)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
    .addr_all  (addr_all),
    .valid_vec (valid_vec),
    .probe     (rd_addr),
    .hit       (rd_hazard)
  );

  assign mem_req = (occ != '0);

  logic unused_pop;
  assign unused_pop = pop;

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr_valid,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BE_W-1:0]   mem_be,
  input logic              buf_empty,
  input logic              rd_hazard,
  input logic [CNT_W-1:0]  occ
);

  a_r1_room_no_stall: assert property (@(posedge clk) disable iff (rst)
    (occ < CNT_W'(DEPTH)) |-> !cpu_stall);

  a_r2_head_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  a_r3_retire_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !(cpu_wr_valid && !cpu_stall)) |=> (occ == $past(occ) - CNT_W'(1)));

  a_r4_full_stalls: assert property (@(posedge clk) disable iff (rst)
    ((occ == CNT_W'(DEPTH)) && !mem_ack) |-> cpu_stall);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  a_r5_ack_frees: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> !cpu_stall);

  a_r6_empty_vs_req: assert property (@(posedge clk) disable iff (rst)
    buf_empty == !mem_req);

  a_r7_idle_no_hazard: assert property (@(posedge clk) disable iff (rst)
    buf_empty |-> !rd_hazard);

endmodule

bind wbuf_top wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr_valid (cpu_wr_valid),
  .cpu_stall    (cpu_stall),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_data     (mem_data),
  .mem_be       (mem_be),
  .buf_empty    (buf_empty),
  .rd_hazard    (rd_hazard),
  .occ          (occ)
);

// File: tb/tb_wbuf_top.sv
module tb_wbuf_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int DEPTH = 4;
  localparam int QN = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_wr_valid = 1'b0;
  logic [AW-1:0] cpu_wr_addr = '0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic [BW-1:0] cpu_wr_be = '0;
  logic          cpu_stall;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_hazard;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [BW-1:0] mem_be;
  logic          mem_ack = 1'b0;
  logic          buf_empty;

  wbuf_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr),
    .cpu_wr_data(cpu_wr_data), .cpu_wr_be(cpu_wr_be),
    .cpu_stall(cpu_stall), .rd_addr(rd_addr), .rd_hazard(rd_hazard),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .mem_ack(mem_ack), .buf_empty(buf_empty)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit accepted = 1'b0;

  // Reference queue of pending writes
  logic [AW-1:0] qa [QN];
  logic [DW-1:0] qd [QN];
  logic [BW-1:0] qb [QN];
  int qh = 0, qt = 0, qn = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    for (int k = 0; k < qn; k++)
      if (qa[(qh + k) % QN] == a) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: drive at the falling edge, compare, update the model for the next rising edge.
  task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [BW-1:0] b, input logic ack, input logic [AW-1:0] ra);
    bit exp_stall;
    @(negedge clk);
    cpu_wr_valid = v; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = b;
    mem_ack = ack; rd_addr = ra;
    #1;
    exp_stall = (qn == DEPTH) && !ack;
    if (qn < DEPTH)      chk(cpu_stall === 1'b0, "R1 stall while room", 64'(cpu_stall), 0);
    else if (ack)        chk(cpu_stall === 1'b0, "R5 stall on full+ack", 64'(cpu_stall), 0);
    else                 chk(cpu_stall === 1'b1, "R4 stall on full", 64'(cpu_stall), 1);
    chk(mem_req === (qn != 0), "R2 mem_req", 64'(mem_req), 64'(qn != 0));
    chk(buf_empty === (qn == 0), "R6 buf_empty", 64'(buf_empty), 64'(qn == 0));
    chk(rd_hazard === model_hit(ra), "R7 rd_hazard", 64'(rd_hazard), 64'(model_hit(ra)));
    if (qn != 0) begin
      chk(mem_addr === qa[qh], "R2 head address", 64'(mem_addr), 64'(qa[qh]));
      if (ack) begin
        chk(mem_data === qd[qh], "R3 order data", 64'(mem_data), 64'(qd[qh]));
        chk(mem_be === qb[qh], "R8 byte enables", 64'(mem_be), 64'(qb[qh]));
        qh = (qh + 1) % QN; qn--;
      end
    end
    accepted = v && !exp_stall;
    if (accepted) begin
      qa[qt] = a; qd[qt] = d; qb[qt] = b;
      qt = (qt + 1) % QN; qn++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic          pv;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    logic [BW-1:0] pb;
    logic          ack;
    logic [AW-1:0] ra;
    int            ack_pct;
    void'($urandom(32'h5eed_0042));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: reset state
    chk(mem_req === 1'b0,   "R9 mem_req", 64'(mem_req), 0);
    chk(cpu_stall === 1'b0, "R9 cpu_stall", 64'(cpu_stall), 0);
    chk(buf_empty === 1'b1, "R9 buf_empty", 64'(buf_empty), 1);
    chk(rd_hazard === 1'b0, "R9 rd_hazard", 64'(rd_hazard), 0);

    // Fill with memory silent (R1), then hold a write against a full buffer (R4)
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, AW'(16 + 4*i), DW'(32'hA000_0000 + i), BW'(1 << i), 1'b0, AW'(20));
    for (int i = 0; i < 3; i++)
      step(1'b1, AW'(32), 32'hBEEF_0001, 4'hF, 1'b0, AW'(32));
    // Same-cycle retire and enqueue while full (R5)
    step(1'b1, AW'(32), 32'hBEEF_0001, 4'hF, 1'b1, AW'(16));
    step(1'b0, '0, '0, '0, 1'b0, AW'(32));
    // Drain, then stray acknowledges while idle (R3)
    for (int i = 0; i < DEPTH + 2; i++)
      step(1'b0, '0, '0, '0, 1'b1, AW'(28));
    // Write coinciding with a stray acknowledge on an empty buffer
    step(1'b1, AW'(40), 32'h1234_5678, 4'h3, 1'b1, AW'(40));
    step(1'b0, '0, '0, '0, 1'b0, AW'(40));
    step(1'b0, '0, '0, '0, 1'b1, AW'(40));
    step(1'b0, '0, '0, '0, 1'b0, AW'(40));

    // Random traffic with sweeping acknowledge rate
    pv = 1'b0; pa = '0; pd = '0; pb = '0;
    accepted = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      case (i / 1000)
        0: ack_pct = 15;
        1: ack_pct = 40;
        2: ack_pct = 70;
        default: ack_pct = 100;
      endcase
      if (!pv || accepted) begin
        pv = ($urandom % 100) < 65;
        pa = AW'({$urandom_range(0, 15), 2'b00});
        pd = $urandom;
        pb = BW'($urandom);
      end
      ack = ($urandom % 100) < ack_pct;
      if (qn != 0 && ($urandom % 2) == 0)
        ra = qa[(qh + ($urandom % qn)) % QN];
      else
        ra = AW'({$urandom_range(0, 15), 2'b00});
      step(pv, pa, pd, pb, ack, ra);
    end
    for (int i = 0; i < DEPTH + 1; i++)
      step(1'b0, '0, '0, '0, 1'b1, '0);
    step(1'b0, '0, '0, '0, 1'b0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule